// File: doc/BRIEF.md
# Multi-core perceptron cluster

The block evaluates a three-layer perceptron for P independent input vectors at once. Every core holds its own input vector, hidden values and outputs in a private node memory, and has its own multiply-accumulate unit. All cores use one weight/threshold memory and one activation lookup table. The host fills both shared memories and each core's input vector, then pulses `start`. When `done` pulses, it reads every core's outputs through `rd_core`/`rd_idx`.

Only core 0 sees the weight memory directly. Each later core gets the same weight, operand index and control flags through one more register stage, so core k runs exactly k cycles behind core 0. As a result the finished node sums of the P cores appear on P consecutive cycles. A rotating selector passes them one per cycle through a single registered table read, and writes each activation back into the node memory of the core that produced it. The table is never claimed by two cores at once, so the pipeline never stalls. Values are 18-bit two's complement with 14 fraction bits (range -8 to 8-2^-14).

Top module: `perceptron_cluster`

## Requirements
- R1: While reset is asserted and right after it is released, `busy` and `done` are low.
- R2: Each node value is computed from a full-precision sum. The sum is the threshold times 1.0 (0x04000) plus every weight times the matching previous-layer value, with all products taken as full-width signed products. The sum is then shifted right by 14 bits, rounding towards minus infinity.
- R3: A shifted node sum above 0x1FFFF saturates to 0x1FFFF (8-2^-14). A sum below -0x20000 saturates to 0x20000 (-8).
- R4: A node's activation is the table entry addressed by bits 17 to 6 of its saturated sum. The table is loaded through `tab_we`/`tab_addr`/`tab_data`.
- R5: The weight memory holds the hidden nodes first, in ascending order, each as (NX+1) words: the threshold, then the weights for inputs 0 to NX-1. The output nodes follow in ascending order, each as (NH+1) words: the threshold, then the weights for hidden nodes 0 to NH-1. Output nodes use the hidden activations as their operands.
- R6: All cores apply the same weights to their own input vectors. `rd_data` returns output `rd_idx` of core `rd_core` combinationally, unaffected by the other cores.
- R7: `in_we` writes `in_data` into input `in_idx` of core `in_core` while the block is idle. While `busy` is high, `in_we` has no effect.
- R8: A `start` seen while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, set by the S+P+2-th rising edge after the accepting edge, where S=(NX+1)·NH+(NH+1)·NO. `busy` falls on that same edge. The total stays within S+3P+9 cycles. A `start` while busy is ignored.
- R9: At most one core hands a finished sum to the activation table per cycle. Those hand-offs follow core order 0 to P-1 for every node, so every core's outputs are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wt_we | input | 1 | Weight memory write enable |
| wt_addr | input | clog2(S) | Weight memory word address |
| wt_data | input | DW | Weight or threshold value |
| tab_we | input | 1 | Activation table write enable |
| tab_addr | input | TB | Activation table address |
| tab_data | input | DW | Activation table entry |
| in_we | input | 1 | Input vector write enable |
| in_core | input | clog2(P) | Core receiving the input value |
| in_idx | input | clog2(NX) | Input index within the vector |
| in_data | input | DW | Input value |
| start | input | 1 | Begin one evaluation of all cores |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when all outputs are written |
| rd_core | input | clog2(P) | Core selected for readback |
| rd_idx | input | clog2(NO) | Output index selected for readback |
| rd_data | output | DW | Selected output value |

## Verification
A wrong weight-cascade depth or a wrong funnel rotation does not stall anything. It shows up as wrong outputs on cores 1 to P-1 while core 0 stays correct, so the bench compares every core's outputs after each `done` against a bit-exact fixed-point model. A broken saturation or a wrong table address slice changes outputs only for large sums, so one scenario drives both rails on purpose. Sequencing faults move the `done` edge, which is checked on the exact cycle, one cycle before and one cycle after.

// File: rtl/perceptron_cluster.sv
module perceptron_cluster #(
  parameter int P    = 4,
  parameter int NX   = 4,
  parameter int NH   = 3,
  parameter int NO   = 2,
  parameter int DW   = 18,
  parameter int FRAC = 14,
  parameter int TB   = 12,
  localparam int S    = (NX + 1) * NH + (NH + 1) * NO,
  localparam int WAW  = $clog2(S),
  localparam int CW   = (P > 1) ? $clog2(P) : 1,
  localparam int XW   = (NX > 1) ? $clog2(NX) : 1,
  localparam int OW   = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wt_we,
  input  logic [WAW-1:0] wt_addr,
  input  logic [DW-1:0]  wt_data,
  input  logic           tab_we,
  input  logic [TB-1:0]  tab_addr,
  input  logic [DW-1:0]  tab_data,
  input  logic           in_we,
  input  logic [CW-1:0]  in_core,
  input  logic [XW-1:0]  in_idx,
  input  logic [DW-1:0]  in_data,
  input  logic           start,
  output logic           busy,
  output logic           done,
  input  logic [CW-1:0]  rd_core,
  input  logic [OW-1:0]  rd_idx,
  output logic [DW-1:0]  rd_data
);

  localparam int NN   = NX + NH + NO;
  localparam int NIW  = $clog2(NN);
  localparam int MAXT = ((NX > NH) ? NX : NH) + 1;
  localparam int MINT = ((NX < NH) ? NX : NH) + 1;
  localparam int MAXN = (NH > NO) ? NH : NO;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int NDW  = (MAXN > 1) ? $clog2(MAXN) : 1;
  localparam int ACCW = 2 * DW + $clog2(MAXT) + 1;
  localparam logic signed [DW-1:0]   ONE  = DW'(1) << FRAC;
  localparam logic signed [DW-1:0]   SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0]   SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [ACCW-1:0] HI   = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] LO   = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  if (P > MINT) begin : g_bad_p
    $error("P must not exceed min(NX,NH)+1");
  end
  if (NH < 2) begin : g_bad_nh
    $error("NH must be at least 2");
  end

  logic [DW-1:0] wmem [S];
  logic [DW-1:0] tab  [1 << TB];
  logic [DW-1:0] nmem [P][NN];

  always_ff @(posedge clk) if (wt_we)  wmem[wt_addr] <= wt_data;
  always_ff @(posedge clk) if (tab_we) tab[tab_addr] <= tab_data;

  // sequencer for core 0
  logic           run, layer;
  logic [NDW-1:0] node;
  logic [TW-1:0]  term;
  logic [WAW-1:0] wa;
  logic           accept, seq_last, seq_fin, fin_write;
  logic [NIW-1:0] seq_op, seq_dest;

  assign accept   = start && !busy;
  assign seq_last = term == TW'(layer ? NH : NX);
  assign seq_fin  = layer && node == NDW'(NO - 1) && seq_last;
  assign seq_op   = (term == '0) ? '0 : NIW'(layer ? NX : 0) + NIW'(term) - NIW'(1);
  assign seq_dest = NIW'(layer ? NX + NH : NX) + NIW'(node);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; layer <= 1'b0; node <= '0; term <= '0; wa <= '0;
    end else if (!run) begin
      if (accept) begin
        run <= 1'b1; layer <= 1'b0; node <= '0; term <= '0; wa <= '0;
      end
    end else begin
      wa <= wa + WAW'(1);
      if (!seq_last) term <= term + TW'(1);
      else begin
        term <= '0;
        if (node == NDW'(layer ? NO - 1 : NH - 1)) begin
          node <= '0;
          if (layer) run <= 1'b0;
          else       layer <= 1'b1;
        end else node <= node + NDW'(1);
      end
    end

  // weight and control cascade, one register per core
  logic           st_v [P], st_first [P], st_last [P], st_fin [P];
  logic [DW-1:0]  st_w [P];
  logic [NIW-1:0] st_op [P], st_dest [P];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int k = 0; k < P; k++) st_v[k] <= 1'b0;
    else begin
      st_v[0] <= run;
      for (int k = 1; k < P; k++) st_v[k] <= st_v[k-1];
    end

  always_ff @(posedge clk) begin
    st_w[0] <= wmem[wa]; st_op[0] <= seq_op; st_dest[0] <= seq_dest;
    st_first[0] <= term == '0; st_last[0] <= seq_last; st_fin[0] <= seq_fin;
    for (int k = 1; k < P; k++) begin
      st_w[k] <= st_w[k-1]; st_op[k] <= st_op[k-1]; st_dest[k] <= st_dest[k-1];
      st_first[k] <= st_first[k-1]; st_last[k] <= st_last[k-1]; st_fin[k] <= st_fin[k-1];
    end
  end

  // per-core multiply-accumulate and saturation
  logic signed [ACCW-1:0] acc [P], acc_n [P];
  logic        [DW-1:0]   sat [P];

  for (genvar c = 0; c < P; c++) begin : g_core
    logic signed [DW-1:0]   xop;
    logic signed [2*DW-1:0] prod;
    logic signed [ACCW-1:0] ext, shifted;
    assign xop     = st_first[c] ? ONE : $signed(nmem[c][st_op[c]]);
    assign prod    = $signed(st_w[c]) * xop;
    assign ext     = {{(ACCW-2*DW){prod[2*DW-1]}}, prod};
    assign acc_n[c] = st_first[c] ? ext : acc[c] + ext;
    assign shifted = acc_n[c] >>> FRAC;
    assign sat[c]  = (shifted > HI) ? SMAX : (shifted < LO) ? SMIN : shifted[DW-1:0];
  end

  logic [P-1:0]   hold_v;
  logic [DW-1:0]  hold_s [P];
  logic [NIW-1:0] hold_dest [P];
  logic           hold_fin [P];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_v <= '0;
    else for (int c = 0; c < P; c++) hold_v[c] <= st_v[c] && st_last[c];

  always_ff @(posedge clk)
    for (int c = 0; c < P; c++) begin
      if (st_v[c]) acc[c] <= acc_n[c];
      if (st_v[c] && st_last[c]) begin
        hold_s[c] <= sat[c]; hold_dest[c] <= st_dest[c]; hold_fin[c] <= st_fin[c];
      end
    end

  // shared activation funnel with rotating core index
  logic [CW-1:0]  rot, fsel, act_core;
  logic           act_v, act_fin;
  logic [DW-1:0]  act_q;
  logic [NIW-1:0] act_dest;

  assign fsel = hold_v[0] ? '0 : rot;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rot <= '0; act_v <= 1'b0;
    end else begin
      rot   <= (fsel == CW'(P - 1)) ? '0 : fsel + CW'(1);
      act_v <= hold_v[fsel];
    end

  always_ff @(posedge clk) begin
    act_q    <= tab[hold_s[fsel][DW-1 -: TB]];
    act_core <= fsel;
    act_dest <= hold_dest[fsel];
    act_fin  <= hold_fin[fsel];
  end

  assign fin_write = act_v && act_fin && act_core == CW'(P - 1);

  always_ff @(posedge clk) begin
    if (in_we && !busy) nmem[in_core][NIW'(in_idx)] <= in_data;
    if (act_v)          nmem[act_core][act_dest]    <= act_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= fin_write;
      if (accept)         busy <= 1'b1;
      else if (fin_write) busy <= 1'b0;
    end

  assign rd_data = nmem[rd_core][NIW'(NX + NH) + NIW'(rd_idx)];

  a_r9_one_sum_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hold_v));
  a_r9_core_order: assert property (@(posedge clk) disable iff (!rst_n)
    (|hold_v) |-> hold_v[fsel]);
  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run) |-> !fin_write);

endmodule

// File: tb/test_perceptron_cluster.sv
module test_perceptron_cluster;
  localparam int P = 4, NX = 4, NH = 3, NO = 2, DW = 18, TB = 12;
  localparam int S   = (NX + 1) * NH + (NH + 1) * NO;
  localparam int WAW = $clog2(S);
  localparam int CW  = $clog2(P);
  localparam int XW  = $clog2(NX);
  localparam int OW  = (NO > 1) ? $clog2(NO) : 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n, wt_we, tab_we, in_we, start, busy, done;
  logic [WAW-1:0] wt_addr;
  logic [DW-1:0]  wt_data, tab_data, in_data, rd_data;
  logic [TB-1:0]  tab_addr;
  logic [CW-1:0]  in_core, rd_core;
  logic [XW-1:0]  in_idx;
  logic [OW-1:0]  rd_idx;

  perceptron_cluster #(.P(P), .NX(NX), .NH(NH), .NO(NO), .DW(DW), .TB(TB)) i_perceptron_cluster (
    .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
    .tab_we(tab_we), .tab_addr(tab_addr), .tab_data(tab_data),
    .in_we(in_we), .in_core(in_core), .in_idx(in_idx), .in_data(in_data),
    .start(start), .busy(busy), .done(done),
    .rd_core(rd_core), .rd_idx(rd_idx), .rd_data(rd_data));

  int nvec = 0, nbad = 0;
  int bw [S];
  int bx [P][NX];

  task automatic check(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tabf(int a);
    int s, v;
    s = (a >= 2048) ? a - 4096 : a;
    v = 8192 + s * 16;
    if (v < 0) v = 0;
    if (v > 16384) v = 16384;
    return v;
  endfunction

  function automatic int activate(longint acc);
    longint s;
    s = acc >>> 14;
    if (s > 131071) s = 131071;
    if (s < -131072) s = -131072;
    return tabf(int'((s >>> 6) & 4095));
  endfunction

  function automatic int ref_out(int c, int k);
    int h [NH];
    longint acc;
    int base;
    for (int j = 0; j < NH; j++) begin
      base = j * (NX + 1);
      acc = longint'(bw[base]) * 16384;
      for (int i = 0; i < NX; i++) acc += longint'(bw[base + 1 + i]) * bx[c][i];
      h[j] = activate(acc);
    end
    base = NH * (NX + 1) + k * (NH + 1);
    acc = longint'(bw[base]) * 16384;
    for (int j = 0; j < NH; j++) acc += longint'(bw[base + 1 + j]) * h[j];
    return activate(acc);
  endfunction

  task automatic load_table;
    for (int a = 0; a < (1 << TB); a++) begin
      @(negedge clk); tab_we = 1'b1; tab_addr = TB'(a); tab_data = DW'(tabf(a));
    end
    @(negedge clk); tab_we = 1'b0;
  endtask

  task automatic load_weights;
    for (int i = 0; i < S; i++) begin
      @(negedge clk); wt_we = 1'b1; wt_addr = WAW'(i); wt_data = DW'(bw[i]);
    end
    @(negedge clk); wt_we = 1'b0;
  endtask

  task automatic load_inputs;
    for (int c = 0; c < P; c++)
      for (int i = 0; i < NX; i++) begin
        @(negedge clk); in_we = 1'b1; in_core = CW'(c); in_idx = XW'(i); in_data = DW'(bx[c][i]);
      end
    @(negedge clk); in_we = 1'b0;
  endtask

  task automatic run_and_check(string req, bit poke);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R8 busy after start", int'(busy), 1);
    for (int n = 1; n <= S + P + 1; n++) begin
      @(negedge clk);
      if (poke && n == 3) begin
        in_we = 1'b1; in_core = '0; in_idx = '0; in_data = 18'h1ABCD; start = 1'b1;
      end else begin
        in_we = 1'b0; start = 1'b0;
      end
    end
    check("R8 done not early", int'(done), 0);
    check("R8 still busy", int'(busy), 1);
    @(negedge clk);
    check("R8 done on time", int'(done), 1);
    check("R8 busy falls with done", int'(busy), 0);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
    for (int c = 0; c < P; c++)
      for (int k = 0; k < NO; k++) begin
        rd_core = CW'(c); rd_idx = OW'(k); #1;
        check(req, int'(rd_data), ref_out(c, k));
      end
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);
  endtask

  task automatic test_basic;
    for (int i = 0; i < S; i++) bw[i] = ((i * 37 + 11) % 97 - 48) * 300;
    for (int c = 0; c < P; c++)
      for (int i = 0; i < NX; i++) bx[c][i] = ((c * 5 + i * 3) % 11) * 1400 - 3000;
    load_weights();
    load_inputs();
    run_and_check("R2 R4 R5 R9 mixed weights per core", 1'b0);
  endtask

  task automatic test_saturate;
    for (int i = 0; i < S; i++) bw[i] = (i % 2 == 0) ? 131071 : 120000;
    for (int c = 0; c < P; c++)
      for (int i = 0; i < NX; i++) bx[c][i] = (c % 2 == 0) ? 131071 : -131072;
    load_weights();
    load_inputs();
    run_and_check("R3 saturated sums", 1'b0);
    rd_core = '0; rd_idx = '0; #1;
    check("R3 positive rail reads top entry", int'(rd_data), tabf(2047));
  endtask

  task automatic test_busy_writes;
    for (int i = 0; i < S; i++) bw[i] = ((i * 53 + 7) % 61 - 30) * 900;
    for (int c = 0; c < P; c++)
      for (int i = 0; i < NX; i++) bx[c][i] = ((c * 7 + i * 5) % 13) * 2000 - 9000;
    load_weights();
    load_inputs();
    run_and_check("R7 in_we ignored while busy", 1'b1);
    run_and_check("R7 stored input unchanged on rerun", 1'b0);
  endtask

  task automatic test_shared_vector;
    for (int c = 0; c < P; c++)
      for (int i = 0; i < NX; i++) bx[c][i] = i * 4000 - 5000;
    load_inputs();
    run_and_check("R6 same vector on every core", 1'b0);
    rd_core = '0; rd_idx = OW'(NO - 1); #1;
    for (int c = 1; c < P; c++) begin
      int r0;
      r0 = int'(rd_data);
      rd_core = CW'(c); #1;
      check("R6 cores agree", int'(rd_data), r0);
      rd_core = '0; #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wt_we = 1'b0; tab_we = 1'b0; in_we = 1'b0; start = 1'b0;
    wt_addr = '0; wt_data = '0; tab_addr = '0; tab_data = '0;
    in_core = '0; in_idx = '0; in_data = '0; rd_core = '0; rd_idx = '0;
    test_reset();
    load_table();
    test_basic();
    test_saturate();
    test_busy_writes();
    test_shared_vector();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule